// File: doc/BRIEF.md
# Serial Converter Frame Sequencer

This block is the digital side of a 12-bit sampling converter's serial port. It watches an active-low frame select and a serial clock, both sampled by a faster system clock. On every frame it presents a 16-bit word on a serial data line: four zero bits, then the 12-bit conversion result, most significant bit first. The conversion core sits outside this block and supplies its result as a parallel 12-bit value, which is captured when the frame opens.

The length of each frame matters. Releasing the select after the 2nd serial-clock falling edge and before the 10th aborts the frame and puts the converter to sleep. A later frame that stays selected past ten falling edges starts the wake-up, and a system-clock timer then measures the power-up delay (1 µs by default). The block also reports when a frame opened, when the converter is acquiring, whether it is powered down, and whether the word being shifted out is trustworthy.

All outputs are registered. Each one responds on the first system-clock edge that samples the input change behind it.

Top module: `sadc_target_if`

## Requirements
- R1: A high-to-low change of `cs_n` gives a one-cycle `sample_strobe` pulse and captures `conv_data` for the frame.
- R2: While `sdo_oe` is high and n serial-clock falling edges have been seen in the frame (n = 0..15), `sdo` equals bit 15−n of the word {4'b0000, captured data}. The MSB therefore appears after the 4th falling edge.
- R3: `sdo_oe` rises when the frame opens and falls on the 16th serial-clock falling edge.
- R4: `cs_n` rising before the 16th falling edge ends the frame and drops `sdo_oe` on that same sampling edge.
- R5: `acquiring` rises on the first serial-clock rising edge after the 13th falling edge of a frame. It clears when the next frame opens, and it is high after reset.
- R6: At frame start, `word_valid` is set to 1 only if the previous frame reached the acquisition point and the block is fully powered. Otherwise it is set to 0, and it holds that value until the next frame opens.
- R7: An abort with 2 to 9 falling edges counted asserts `powered_down` from any power state. An abort with 0, 1 or 10 or more edges counted does not.
- R8: While asleep, a frame with fewer than 11 falling edges leaves `powered_down` high. A frame reaching its 11th falling edge starts the wake-up, and `powered_down` falls once WAKE_CYC system-clock cycles have passed since that frame opened (or at once after the 11th edge, if the delay has already elapsed).
- R9: A frame that opens while `powered_down` is high reports `word_valid` low.
- R10: After reset, `sdo_oe`, `sample_strobe`, `word_valid` and `powered_down` are low, and `acquiring` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low (synchronous to clk) |
| sclk | input | 1 | Serial clock level (synchronous to clk), idles high |
| conv_data | input | 12 | Parallel conversion result |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| sample_strobe | output | 1 | One-cycle pulse when a frame opens |
| acquiring | output | 1 | Converter is in its acquisition phase |
| powered_down | output | 1 | Converter is asleep or still waking |
| word_valid | output | 1 | Word of the current frame is valid |

## Verification
The bench aims at the edges of the sleep window: aborts after exactly 1, 2, 9, 10 and 12 falling edges. A design with the window off by one would sleep on a harmless abort, or stay awake when it should sleep. It also tries wake-up dummy frames of 8 and 11 edges, a frame opened before the wake timer expires, and an abort during wake-up. Errors here would show as a converter that wakes on too short a frame, reports stale data as valid, or ignores a second sleep request. Frames cut short before the acquisition point are followed by a full frame, which catches a validity flag that ignores the missed acquisition.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    parameter int unsigned DATA_W   = 12;
    parameter int unsigned LEAD_Z   = 4;
    parameter int unsigned WORD_W   = DATA_W + LEAD_Z;
    parameter int unsigned CNT_W    = $clog2(WORD_W + 1);
    parameter int unsigned SLEEP_LO = 2;
    parameter int unsigned SLEEP_HI = 9;
    parameter int unsigned WAKE_AT  = 11;
    parameter int unsigned ACQ_AT   = 13;

    typedef enum logic [1:0] {
        PWR_ON   = 2'd0,
        PWR_OFF  = 2'd1,
        PWR_WAKE = 2'd2
    } pwr_e;

    typedef struct packed {
        logic cs_fall;
        logic cs_rise;
        logic sc_fall;
        logic sc_rise;
    } ev_t;

    function automatic logic [WORD_W-1:0] frame_word(input logic [DATA_W-1:0] d);
        return {{LEAD_Z{1'b0}}, d};
    endfunction

endpackage

// File: rtl/sadc_edges.sv
module sadc_edges #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b1;
            else     prev_q[g] <= lvl[g];
        end
        assign fall[g] = prev_q[g] & ~lvl[g];
        assign rise[g] = ~prev_q[g] & lvl[g];
    end
endmodule

// File: rtl/sadc_frame.sv
module sadc_frame
    import sadc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ev_t               ev,
    input  logic              pwr_on,
    input  logic [DATA_W-1:0] data,
    output logic              in_frame,
    output logic [CNT_W-1:0]  fall_cnt,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              strobe,
    output logic              acq,
    output logic              valid
);
    localparam logic [CNT_W-1:0] LAST_M1 = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ACQ_C   = CNT_W'(ACQ_AT);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            fall_cnt <= '0;
            sh_q     <= '0;
            sdo_oe   <= 1'b0;
            strobe   <= 1'b0;
            acq      <= 1'b1;
            valid    <= 1'b0;
        end else begin
            strobe <= ev.cs_fall;
            if (ev.cs_fall) begin
                in_frame <= 1'b1;
                fall_cnt <= '0;
                sh_q     <= frame_word(data);
                sdo_oe   <= 1'b1;
                acq      <= 1'b0;
                valid    <= acq & pwr_on;
            end else if (ev.cs_rise) begin
                in_frame <= 1'b0;
                sdo_oe   <= 1'b0;
            end else if (in_frame) begin
                if (ev.sc_fall) begin
                    fall_cnt <= fall_cnt + 1'b1;
                    sh_q     <= {sh_q[WORD_W-2:0], 1'b0};
                    if (fall_cnt == LAST_M1) begin
                        sdo_oe   <= 1'b0;
                        in_frame <= 1'b0;
                    end
                end
                if (ev.sc_rise && fall_cnt >= ACQ_C) acq <= 1'b1;
            end
        end
    end

    assign sdo = sh_q[WORD_W-1];
endmodule

// File: rtl/sadc_power.sv
module sadc_power
    import sadc_pkg::*;
#(
    parameter int unsigned WAKE_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  ev_t              ev,
    input  logic             in_frame,
    input  logic [CNT_W-1:0] fall_cnt,
    output pwr_e             state
);
    localparam int unsigned      TMR_W  = $clog2(WAKE_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LIM = TMR_W'(WAKE_CYC);
    localparam logic [CNT_W-1:0] LO_C   = CNT_W'(SLEEP_LO);
    localparam logic [CNT_W-1:0] HI_C   = CNT_W'(SLEEP_HI);
    localparam logic [CNT_W-1:0] WK_M1  = CNT_W'(WAKE_AT - 1);

    logic [TMR_W-1:0] tmr_q;
    logic             abort, sleep_req, wake_req, tmr_done;

    assign abort     = ev.cs_rise & in_frame;
    assign sleep_req = abort && fall_cnt >= LO_C && fall_cnt <= HI_C;
    assign wake_req  = in_frame & ev.sc_fall & ~ev.cs_rise & (fall_cnt == WK_M1);
    assign tmr_done  = tmr_q >= TMR_LIM;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_ON;
            tmr_q <= '0;
        end else if (sleep_req) begin
            state <= PWR_OFF;
            tmr_q <= '0;
        end else begin
            unique case (state)
                PWR_OFF: begin
                    if (ev.cs_fall)                    tmr_q <= TMR_W'(1);
                    else if (abort)                    tmr_q <= '0;
                    else if (tmr_q != '0 && !tmr_done) tmr_q <= tmr_q + 1'b1;
                    if (wake_req) state <= PWR_WAKE;
                end
                PWR_WAKE: begin
                    if (!tmr_done) tmr_q <= tmr_q + 1'b1;
                    else           state <= PWR_ON;
                end
                default: tmr_q <= '0;
            endcase
        end
    end
endmodule

// File: rtl/sadc_target_if.sv
module sadc_target_if
    import sadc_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 100000,
    parameter int unsigned WAKE_NS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              sample_strobe,
    output logic              acquiring,
    output logic              powered_down,
    output logic              word_valid
);
    localparam int unsigned WAKE_CYC = (CLK_KHZ * WAKE_NS) / 1000000;

    logic [1:0]       fall_v, rise_v;
    ev_t              ev;
    logic             in_frame;
    logic [CNT_W-1:0] fall_cnt;
    pwr_e             pstate;

    sadc_edges #(.N(2)) u_edges (
        .clk (clk),
        .rst (rst),
        .lvl ({sclk, cs_n}),
        .fall(fall_v),
        .rise(rise_v)
    );

    assign ev = '{cs_fall: fall_v[0], cs_rise: rise_v[0],
                  sc_fall: fall_v[1], sc_rise: rise_v[1]};

    sadc_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .pwr_on  (pstate == PWR_ON),
        .data    (conv_data),
        .in_frame(in_frame),
        .fall_cnt(fall_cnt),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe),
        .strobe  (sample_strobe),
        .acq     (acquiring),
        .valid   (word_valid)
    );

    sadc_power #(.WAKE_CYC(WAKE_CYC)) u_power (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .in_frame(in_frame),
        .fall_cnt(fall_cnt),
        .state   (pstate)
    );

    assign powered_down = (pstate != PWR_ON);
endmodule

// File: rtl/sadc_checker.sv
module sadc_checker (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sdo_oe,
    input logic sample_strobe,
    input logic acquiring,
    input logic powered_down,
    input logic word_valid
);
    p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |=> !sample_strobe);

    p_oe_needs_select_r4: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> !sdo_oe);

    p_frame_opens_driving_r3: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> sdo_oe);

    p_acq_cleared_at_open_r5: assert property (@(posedge clk) disable iff (rst)
        sample_strobe |-> !acquiring);

    p_valid_needs_power_r6: assert property (@(posedge clk) disable iff (rst)
        (sample_strobe && word_valid) |-> !powered_down);

    p_sleep_ends_frame_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(powered_down) |-> !sdo_oe);
endmodule

bind sadc_target_if sadc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n         (cs_n),
    .sdo_oe       (sdo_oe),
    .sample_strobe(sample_strobe),
    .acquiring    (acquiring),
    .powered_down (powered_down),
    .word_valid   (word_valid)
);

// File: tb/sim_sadc_target_if.sv
module sim_sadc_target_if;
    localparam int H    = 3;
    localparam int GAP  = 4;
    localparam int WAKE = 100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] conv_data = '0;
    logic        sdo, sdo_oe, sample_strobe, acquiring, powered_down, word_valid;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sadc_target_if u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .conv_data(conv_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .sample_strobe(sample_strobe),
        .acquiring(acquiring), .powered_down(powered_down), .word_valid(word_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    bit        m_pcs = 1, m_psc = 1, m_in = 0, m_oe = 0, m_acq = 1, m_str = 0, m_val = 0;
    int        m_cnt = 0, m_st = 0, m_tmr = 0;
    bit [15:0] m_word = '0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_pcs = 1; m_psc = 1; m_in = 0; m_oe = 0; m_acq = 1; m_str = 0; m_val = 0;
            m_cnt = 0; m_st = 0; m_tmr = 0; m_word = '0;
        end else begin
            bit opened, closed, dn, up, was_in, was_acq;
            int was_cnt, was_st;
            opened = m_pcs && !cs_n;  closed = !m_pcs && cs_n;
            dn = m_psc && !sclk;      up = !m_psc && sclk;
            was_in = m_in; was_cnt = m_cnt; was_st = m_st; was_acq = m_acq;
            // power (0 on, 1 asleep, 2 waking)
            if (closed && was_in && was_cnt >= 2 && was_cnt <= 9) begin
                m_st = 1; m_tmr = 0;
            end else if (was_st == 1) begin
                if (opened) m_tmr = 1;
                else if (closed && was_in) m_tmr = 0;
                else if (m_tmr > 0 && m_tmr < WAKE) m_tmr++;
                if (was_in && dn && !closed && was_cnt == 10) m_st = 2;
            end else if (was_st == 2) begin
                if (m_tmr < WAKE) m_tmr++;
                else m_st = 0;
            end
            // frame
            m_str = opened;
            if (opened) begin
                m_in = 1; m_cnt = 0; m_word = {4'b0000, conv_data}; m_oe = 1;
                m_acq = 0; m_val = was_acq && (was_st == 0);
            end else if (closed) begin
                m_in = 0; m_oe = 0;
            end else if (was_in) begin
                if (dn) begin
                    m_cnt++;
                    m_word = m_word << 1;
                    if (m_cnt == 16) begin m_oe = 0; m_in = 0; end
                end
                if (up && was_cnt >= 13) m_acq = 1;
            end
            m_pcs = cs_n; m_psc = sclk;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 sample_strobe", sample_strobe, m_str);
            chk("R3 sdo_oe", sdo_oe, m_oe);
            if (m_oe) chk("R2 sdo bit", sdo, m_word[15]);
            chk("R5 acquiring", acquiring, m_acq);
            chk("R6 word_valid", word_valid, m_val);
            chk("R8 powered_down", powered_down, m_st != 0);
        end
    end

    bit seen_valid;

    task automatic frame(input int falls, input logic [11:0] d);
        @(negedge clk);
        conv_data = d;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        seen_valid = word_valid;
        for (int i = 0; i < falls; i++) begin
            sclk = 1'b0; repeat (H) @(negedge clk);
            sclk = 1'b1; repeat (H) @(negedge clk);
        end
        cs_n = 1'b1;
        @(negedge clk);
        if (falls < 16) chk("R4 oe low after abort", sdo_oe, 0);
        repeat (GAP) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 oe", sdo_oe, 0);
        chk("R10 strobe", sample_strobe, 0);
        chk("R10 valid", word_valid, 0);
        chk("R10 pd", powered_down, 0);
        chk("R10 acq", acquiring, 1);
        rst = 1'b0;
        frame(16, 12'hA5C);
        chk("R6 first frame valid", seen_valid, 1);
        frame(16, 12'h3F0);
        frame(16, 12'h001);
        frame(16, 12'hFFF);
        frame(12, 12'h555);
        chk("R7 abort at 12 no sleep", powered_down, 0);
        frame(16, 12'hAAA);
        chk("R6 after early abort invalid", seen_valid, 0);
        frame(16, 12'h800);
        chk("R6 valid again", seen_valid, 1);
        frame(1, 12'h123);
        chk("R7 abort at 1 no sleep", powered_down, 0);
        frame(10, 12'h456);
        chk("R7 abort at 10 no sleep", powered_down, 0);
        frame(16, 12'h789);
        frame(5, 12'hABC);
        chk("R7 abort at 5 sleeps", powered_down, 1);
        frame(8, 12'h0F0);
        chk("R8 short dummy stays asleep", powered_down, 1);
        chk("R9 frame while asleep invalid", seen_valid, 0);
        frame(11, 12'h0F0);
        frame(16, 12'h1E1);
        chk("R9 frame before wake done invalid", seen_valid, 0);
        frame(16, 12'h2D2);
        chk("R8 awake after timer", powered_down, 0);
        chk("R6 valid after wake", seen_valid, 1);
        frame(2, 12'h3C3);
        chk("R7 abort at 2 sleeps", powered_down, 1);
        frame(12, 12'h4B4);
        frame(3, 12'h5A5);
        chk("R7 abort during wake sleeps", powered_down, 1);
        frame(11, 12'h696);
        repeat (WAKE + 20) @(negedge clk);
        chk("R8 wake completes when idle", powered_down, 0);
        frame(16, 12'h787);
        frame(9, 12'h878);
        chk("R7 abort at 9 sleeps", powered_down, 1);
        frame(16, 12'h969);
        repeat (WAKE + 20) @(negedge clk);
        frame(16, 12'hC3C);
        frame(16, 12'hE1E);
        chk("R6 valid after 16-edge wake", seen_valid, 1);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule